// File: doc/BRIEF.md
# Frame-Synchronous Handset Control Outputs

This block drives two control pins of a cordless handset controller that sits on a time-division duplex link. The first pin gates the audio that modulates the transmitter. It can be held at a fixed level, follow the duplex frame signal, or follow its inverse. With a single-synthesizer radio, this lets the transmit audio be cut while the radio is receiving.

The second pin drives a ringer transducer. It can sit at a fixed level or be released to high impedance. It can also carry a square-wave tone divided from the master clock. At a 15.36 MHz master clock, a toggle every 4096 clocks gives an 1875 Hz tone. The pin is presented as a data bit plus an output enable, so the pad logic outside the block forms the actual three-state driver.

Both behaviours are picked by 2-bit mode fields that come from control registers elsewhere, and they arrive here as plain inputs synchronous to the master clock. The frame signal comes from another timing domain, so it passes through a synchronizer before use. All outputs are registered.

Top module: `line_ctl`

## Requirements
- R1: While `rst_i` is high, and after the first rising clock edge with `rst_i` high, `chop_o`, `ring_data_o` and `ring_oe_o` are all 0.
- R2: Chop mode 2'b00 drives `chop_o` low and mode 2'b01 drives it high. The level appears one clock after the mode is sampled.
- R3: Chop mode 2'b10 makes `chop_o` equal to `tdd_i` as sampled three rising edges earlier: two synchronizer stages plus the output register.
- R4: Chop mode 2'b11 makes `chop_o` the inverse of `tdd_i`, with the same three-edge delay as R3.
- R5: Ringer mode 2'b00 gives `ring_data_o`=0 and mode 2'b01 gives `ring_data_o`=1. The value appears one clock after the mode is sampled.
- R6: Ringer mode 2'b11 is three-state: `ring_oe_o`=0 and `ring_data_o`=0, one clock after the mode is sampled.
- R7: Ringer mode 2'b10 produces a square wave on `ring_data_o`. The output is low for the first HALF_PERIOD clocks after entering the mode, then toggles every HALF_PERIOD clocks. The default HALF_PERIOD is 4096, which divides the clock by 8192.
- R8: Leaving tone mode for any time and entering it again restarts the tone phase, with a full low half-period first.
- R9: `ring_oe_o` is 1 one clock after any ringer mode other than 2'b11 is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tdd_i | input | 1 | Duplex frame signal, asynchronous to clk_i |
| chop_mode_i | input | 2 | Chop behaviour: 00 low, 01 high, 10 follow frame, 11 inverted frame |
| ring_mode_i | input | 2 | Ringer behaviour: 00 low, 01 high, 10 tone, 11 three-state |
| chop_o | output | 1 | Registered transmit-audio gate |
| ring_data_o | output | 1 | Registered ringer data |
| ring_oe_o | output | 1 | Registered ringer output enable |

## Verification
A synchronizer stage that is lost or added shows as `chop_o` moving one edge early or late against the frame signal, and this is visible on the first frame transition in modes 2'b10 and 2'b11. A tone divider that is off by one, or that keeps its count across a mode change, shows as a half-period of the wrong length. This appears within HALF_PERIOD+1 clocks of entering tone mode. A wrong enable or data decode appears one clock after the mode is sampled.

// File: rtl/line_ctl_pkg.sv
package line_ctl_pkg;

  typedef enum logic [1:0] {
    CHOP_LOW    = 2'b00,
    CHOP_HIGH   = 2'b01,
    CHOP_FOLLOW = 2'b10,
    CHOP_INVERT = 2'b11
  } chop_mode_e;

  typedef enum logic [1:0] {
    RING_LOW  = 2'b00,
    RING_HIGH = 2'b01,
    RING_TONE = 2'b10,
    RING_HIZ  = 2'b11
  } ring_mode_e;

endpackage

// File: rtl/lc_sync.sv
module lc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[i] <= 1'b0;
        else       stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[i] <= 1'b0;
        else       stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lc_chop.sv
module lc_chop
  import line_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  chop_mode_e mode_i,
  input  logic       frame_i,
  output logic       chop_o
);

  logic chop_d;

  always_comb begin
    unique case (mode_i)
      CHOP_LOW:    chop_d = 1'b0;
      CHOP_HIGH:   chop_d = 1'b1;
      CHOP_FOLLOW: chop_d = frame_i;
      CHOP_INVERT: chop_d = ~frame_i;
      default:     chop_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) chop_o <= 1'b0;
    else       chop_o <= chop_d;
  end

endmodule

// File: rtl/lc_ringer.sv
module lc_ringer
  import line_ctl_pkg::*;
#(
  parameter int HALF_PERIOD = 4096
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  ring_mode_e mode_i,
  output logic       data_o,
  output logic       oe_o
);

  localparam int              CW   = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0]   LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          was_tone_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q      <= '0;
      data_o     <= 1'b0;
      oe_o       <= 1'b0;
      was_tone_q <= 1'b0;
    end else begin
      was_tone_q <= (mode_i == RING_TONE);
      unique case (mode_i)
        RING_LOW: begin
          cnt_q  <= '0;
          data_o <= 1'b0;
          oe_o   <= 1'b1;
        end
        RING_HIGH: begin
          cnt_q  <= '0;
          data_o <= 1'b1;
          oe_o   <= 1'b1;
        end
        RING_HIZ: begin
          cnt_q  <= '0;
          data_o <= 1'b0;
          oe_o   <= 1'b0;
        end
        RING_TONE: begin
          oe_o <= 1'b1;
          if (!was_tone_q) begin
            cnt_q  <= '0;
            data_o <= 1'b0;
          end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            data_o <= ~data_o;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_q  <= '0;
          data_o <= 1'b0;
          oe_o   <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/line_ctl.sv
module line_ctl
  import line_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_PERIOD = 4096
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tdd_i,
  input  logic [1:0] chop_mode_i,
  input  logic [1:0] ring_mode_i,
  output logic       chop_o,
  output logic       ring_data_o,
  output logic       ring_oe_o
);

  logic frame_sync;

  lc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (tdd_i),
    .q_o   (frame_sync)
  );

  lc_chop u_chop (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .mode_i  (chop_mode_e'(chop_mode_i)),
    .frame_i (frame_sync),
    .chop_o  (chop_o)
  );

  lc_ringer #(.HALF_PERIOD(HALF_PERIOD)) u_ring (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (ring_mode_e'(ring_mode_i)),
    .data_o (ring_data_o),
    .oe_o   (ring_oe_o)
  );

endmodule

// File: rtl/line_ctl_checker.sv
module line_ctl_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_PERIOD = 4096
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       tdd_i,
  input logic [1:0] chop_mode_i,
  input logic [1:0] ring_mode_i,
  input logic       chop_o,
  input logic       ring_data_o,
  input logic       ring_oe_o
);

  logic [2:0]  age_q;
  logic [31:0] run_q;
  logic        prev_data_q;
  logic        tone_d_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      age_q       <= '0;
      run_q       <= '0;
      prev_data_q <= 1'b0;
      tone_d_q    <= 1'b0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      prev_data_q <= ring_data_o;
      tone_d_q    <= (ring_mode_i == 2'b10);
      if (ring_mode_i != 2'b10 || !tone_d_q) run_q <= '0;
      else if (ring_data_o != prev_data_q)   run_q <= '0;
      else                                   run_q <= run_q + 32'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!chop_o && !ring_data_o && !ring_oe_o)); // R1

  AST_CHOP_FORCED: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 3'd1 && $past(chop_mode_i[1]) == 1'b0) |-> chop_o == $past(chop_mode_i[0])); // R2

  if (SYNC_STAGES == 2) begin : g_frame_chk
    AST_CHOP_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (age_q >= 3'd4 && $past(chop_mode_i) == 2'b10) |-> chop_o == $past(tdd_i, 3)); // R3
    AST_CHOP_INVERT: assert property (@(posedge clk_i) disable iff (rst_i)
      (age_q >= 3'd4 && $past(chop_mode_i) == 2'b11) |-> chop_o != $past(tdd_i, 3)); // R4
  end

  AST_RING_FIXED: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 3'd1 && $past(ring_mode_i[1]) == 1'b0) |-> ring_data_o == $past(ring_mode_i[0])); // R5

  AST_RING_HIZ: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 3'd1 && $past(ring_mode_i) == 2'b11) |-> (!ring_oe_o && !ring_data_o)); // R6

  AST_TONE_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q <= 32'(HALF_PERIOD + 1)); // R7

  AST_TONE_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 3'd1 && ring_mode_i == 2'b10 && !tone_d_q) |=> !ring_data_o); // R8

  AST_RING_DRIVEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q >= 3'd1 && $past(ring_mode_i) != 2'b11) |-> ring_oe_o); // R9

endmodule

bind line_ctl line_ctl_checker #(
  .SYNC_STAGES (SYNC_STAGES),
  .HALF_PERIOD (HALF_PERIOD)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .tdd_i       (tdd_i),
  .chop_mode_i (chop_mode_i),
  .ring_mode_i (ring_mode_i),
  .chop_o      (chop_o),
  .ring_data_o (ring_data_o),
  .ring_oe_o   (ring_oe_o)
);

// File: tb/line_ctl_tb.sv
module line_ctl_tb;

  localparam int HALF = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tdd = 1'b0;
  logic [1:0] chop_mode = 2'b00;
  logic [1:0] ring_mode = 2'b00;
  logic       chop_o, ring_data_o, ring_oe_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  line_ctl #(.SYNC_STAGES(2), .HALF_PERIOD(HALF)) u_dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .tdd_i       (tdd),
    .chop_mode_i (chop_mode),
    .ring_mode_i (ring_mode),
    .chop_o      (chop_o),
    .ring_data_o (ring_data_o),
    .ring_oe_o   (ring_oe_o)
  );

  // Behavioural reference: history of frame samples and tone age.
  bit    h1 = 0, h2 = 0;
  bit    e_chop = 0, e_data = 0, e_oe = 0;
  bit    prev_tone = 0;
  int    tone_age = 0;
  int    tone_entries = 0;
  string chop_tag = "R1", data_tag = "R1", oe_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      h1 = 0; h2 = 0;
      e_chop = 0; e_data = 0; e_oe = 0;
      prev_tone = 0; tone_age = 0;
      chop_tag = "R1"; data_tag = "R1"; oe_tag = "R1";
    end else begin
      case (chop_mode)
        2'b00: begin e_chop = 0;   chop_tag = "R2"; end
        2'b01: begin e_chop = 1;   chop_tag = "R2"; end
        2'b10: begin e_chop = h2;  chop_tag = "R3"; end
        default: begin e_chop = !h2; chop_tag = "R4"; end
      endcase
      h2 = h1;
      h1 = tdd;
      e_oe   = (ring_mode != 2'b11);
      oe_tag = e_oe ? "R9" : "R6";
      if (ring_mode == 2'b10) begin
        if (!prev_tone) begin
          tone_age = 0;
          tone_entries++;
        end else tone_age++;
        e_data   = ((tone_age / HALF) % 2) == 1;
        data_tag = (tone_entries > 1) ? "R8" : "R7";
      end else begin
        e_data   = (ring_mode == 2'b01);
        data_tag = (ring_mode == 2'b11) ? "R6" : "R5";
      end
      prev_tone = (ring_mode == 2'b10);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (chop_o !== e_chop) begin
        errors++;
        $display("FAIL %s chop_o actual=%0b expected=%0b t=%0t", chop_tag, chop_o, e_chop, $time);
      end
      checks++;
      if (ring_data_o !== e_data) begin
        errors++;
        $display("FAIL %s ring_data_o actual=%0b expected=%0b t=%0t", data_tag, ring_data_o, e_data, $time);
      end
      checks++;
      if (ring_oe_o !== e_oe) begin
        errors++;
        $display("FAIL %s ring_oe_o actual=%0b expected=%0b t=%0t", oe_tag, ring_oe_o, e_oe, $time);
      end
    end
  end

  logic [7:0] lfsr = 8'hA5;

  // per > 0: toggle frame every per cycles; per < 0: pseudo-random frame.
  task automatic run(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (per > 0 && (i % per) == 0) tdd = ~tdd;
      else if (per < 0) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tdd  = lfsr[0];
      end
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    run(5, 0);                                     // R1 reset state
    @(negedge clk); rst = 1'b0;
    chop_mode = 2'b01; ring_mode = 2'b01; run(10, 0);  // R2 R5 high
    chop_mode = 2'b10; ring_mode = 2'b00; run(40, 5);  // R3 regular frame
    chop_mode = 2'b11; ring_mode = 2'b11; run(40, 3);  // R4 R6
    run(30, -1);                                   // R4 irregular frame
    chop_mode = 2'b10; ring_mode = 2'b10; run(110, -1); // R3 R7 tone
    ring_mode = 2'b00; run(5, 4);
    ring_mode = 2'b10; run(30, 4);                 // R8 restart
    ring_mode = 2'b11; run(3, 0);
    ring_mode = 2'b10; run(7, 0);                  // R8 mid-phase exit
    ring_mode = 2'b01; run(1, 0);
    ring_mode = 2'b10; run(50, 2);                 // R8
    chop_mode = 2'b00; run(10, 0);                 // R2 low
    for (int i = 0; i < 24; i++) begin             // R2-R4 mode each cycle
      @(negedge clk);
      chop_mode = 2'(i % 4);
      tdd = ~tdd;
    end
    for (int i = 0; i < 24; i++) begin             // R5 R6 R9 ringer changes
      @(negedge clk);
      ring_mode = 2'((i * 3) % 4);
    end
    ring_mode = 2'b10; run(20, 0);
    @(negedge clk); rst = 1'b1;                    // R1 reset during tone
    run(2, 0);
    @(negedge clk); rst = 1'b0;
    run(40, 6);                                    // R7 tone after reset
    finish_run();
  end

endmodule